// File: doc/BRIEF.md
# Eight-bit tick counter with divider and edge-selectable input

This block counts ticks in an 8-bit register. A tick comes either from an internal instruction-cycle strobe or from an edge on an external pin. The internal strobe fires once every two oscillator cycles, or once every four, as set by a divide option bit. The pin is brought into the oscillator domain through a two-stage synchronizer. A select bit decides whether a rising or a falling level change counts as an edge. An 8-bit prescaler can sit between the chosen source and the counter and pass one tick in 2, 4, ..., 256. A bypass input removes the prescaler and gives a ratio of 1:1.

The host can load the counter directly through a write port. Any such load also empties the prescaler, so the next count comes a full prescaler period after the load. A sticky flag records every roll-over of the counter from its all-ones value to zero. The flag stays set until the host clears it.

Three small state machines carry the block's timing:
- The divider phase machine has states PH_A, PH_B, PH_C and PH_D. It steps PH_A→PH_B→PH_C→PH_D→PH_A. In divide-by-2 mode it also takes PH_B→PH_A. The strobe fires on leaving PH_B in divide-by-2 mode, and on leaving PH_D in divide-by-4 mode.
- The pin level tracker has states LVL_LO and LVL_HI. It takes LVL_LO→LVL_HI when the synchronized pin reads 1, and LVL_HI→LVL_LO when it reads 0. An edge is reported on the transition that matches the selected polarity.
- The overflow flag machine has states FLG_CLEAR and FLG_SET. It takes FLG_CLEAR→FLG_SET on a roll-over, and FLG_SET→FLG_CLEAR on a host clear when no roll-over happens in the same cycle.

Top module: `tmr8_unit`

## Requirements
- R1: While rst_n is low, count_q is 0x00 and ovf_flag is 0. The prescaler, the divider phase (PH_A) and the synchronizer also clear.
- R2: With src_ext=0 and pre_bypass=1, count_q rises by one once per 2 oscillator cycles when div4_sel=0, and once per 4 when div4_sel=1. The divider phase runs freely from reset; a counter write does not restart it.
- R3: With pre_bypass=0, the prescaler advances on each source tick. A tick reaches the counter only when the low k+1 bits of the prescaler are all ones, where k=pre_ratio. This gives a ratio of 1:2^(k+1), and the prescaler then wraps naturally. With pre_bypass=1 the prescaler holds its value and every source tick counts.
- R4: With src_ext=1, a 0→1 pin change counts when edge_fall=0, and a 1→0 change counts when edge_fall=1. With bypass, count_q changes at the third rising oscillator edge after the pin changes. The pin's high and low times must each be at least two oscillator cycles.
- R5: A cycle with wr_en=1 loads wr_data into the counter and clears the prescaler to zero. A tick in that same cycle is dropped.
- R6: ovf_flag sets when a tick moves count_q from 0xFF to 0x00. A write that loads 0x00 does not set it.
- R7: ovf_flag stays set until ovf_clr=1 is sampled. If a roll-over happens in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External count input, asynchronous |
| edge_fall | input | 1 | 1: count falling pin edges, 0: rising |
| src_ext | input | 1 | 1: external pin source, 0: internal strobe |
| div4_sel | input | 1 | Internal strobe divide: 0 = /2, 1 = /4 |
| pre_bypass | input | 1 | 1: prescaler bypassed (1:1) |
| pre_ratio | input | 3 | Prescaler ratio code k, ratio 1:2^(k+1) |
| wr_en | input | 1 | Load counter and clear prescaler |
| wr_data | input | 8 | Value loaded into the counter |
| ovf_clr | input | 1 | Clears the overflow flag |
| count_q | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky roll-over flag |

## Verification
A wrong divider phase shows at once as a count step landing one or more oscillator cycles early or late. A prescaler that fails to clear on a write shifts the first count after the load. That shift can take up to 256 source ticks to show for ratio code 7. A wrong level-tracker state shows as a count on the wrong pin polarity, or as a lost count three cycles after a pin change. A stuck or missed flag state shows on the first roll-over or clear. The bench therefore keeps a cycle-level reference of the counter and flag, and compares against it on every cycle rather than only at the end.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    // divider phase of the internal instruction-cycle strobe
    typedef enum logic [1:0] {PH_A, PH_B, PH_C, PH_D} phase_t;
    // last synchronized level seen on the external pin
    typedef enum logic {LVL_LO, LVL_HI} lvl_t;
    // sticky overflow flag
    typedef enum logic {FLG_CLEAR, FLG_SET} flg_t;
endpackage

// File: rtl/tmr8_phase.sv
module tmr8_phase
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic div4_sel,
    output logic int_tick
);
    phase_t ph_q, ph_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_A;
        else        ph_q <= ph_d;
    end

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_A: ph_d = PH_B;
            PH_B: ph_d = div4_sel ? PH_C : PH_A;
            PH_C: ph_d = PH_D;
            PH_D: ph_d = PH_A;
        endcase
    end

    always_comb begin
        int_tick = 1'b0;
        unique case (ph_q)
            PH_B:    int_tick = !div4_sel;
            PH_D:    int_tick = div4_sel;
            default: int_tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr8_edge.sv
module tmr8_edge
    import tmr8_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_tick
);
    logic [SYNC_N-1:0] sy_q;
    logic              lvl_now;
    lvl_t              st_q, st_d;

    generate
        if (SYNC_N == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sy_q <= '0;
                else        sy_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sy_q <= '0;
                else        sy_q <= {sy_q[SYNC_N-2:0], pin};
            end
        end
    endgenerate

    assign lvl_now = sy_q[SYNC_N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LVL_LO;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LVL_LO: if (lvl_now)  st_d = LVL_HI;
            LVL_HI: if (!lvl_now) st_d = LVL_LO;
        endcase
    end

    always_comb begin
        edge_tick = 1'b0;
        unique case (st_q)
            LVL_LO: edge_tick = lvl_now && !fall_sel;
            LVL_HI: edge_tick = !lvl_now && fall_sel;
        endcase
    end
endmodule

// File: rtl/tmr8_presc.sv
module tmr8_presc #(
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_tick,
    input  logic          bypass,
    input  logic [RW-1:0] ratio,
    input  logic          clr,
    output logic          out_tick
);
    localparam int PW = 1 << RW;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] mask;
    logic          hit;

    // k+1 low ones for ratio code k
    assign mask = {PW{1'b1}} >> (RW'(PW - 1) - ratio);
    assign hit  = (pre_q & mask) == mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pre_q <= '0;
        else if (clr)                pre_q <= '0;
        else if (src_tick && !bypass) pre_q <= pre_q + PW'(1);
    end

    assign out_tick = src_tick && (bypass || hit);
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          ovf_clr,
    output logic [CW-1:0] count_q,
    output logic          ovf_flag
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    logic rollover;
    flg_t fl_q, fl_d;

    assign rollover = tick && !wr_en && (count_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count_q <= '0;
        else if (wr_en) count_q <= wr_data;
        else if (tick)  count_q <= count_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= FLG_CLEAR;
        else        fl_q <= fl_d;
    end

    always_comb begin
        fl_d = fl_q;
        unique case (fl_q)
            FLG_CLEAR: if (rollover)             fl_d = FLG_SET;
            FLG_SET:   if (ovf_clr && !rollover) fl_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        ovf_flag = 1'b0;
        unique case (fl_q)
            FLG_CLEAR: ovf_flag = 1'b0;
            FLG_SET:   ovf_flag = 1'b1;
        endcase
    end
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit #(
    parameter int CW     = 8,
    parameter int RW     = 3,
    parameter int SYNC_N = 2
) (
    input  logic          clk_osc,
    input  logic          rst_n,
    input  logic          ext_pin,
    input  logic          edge_fall,
    input  logic          src_ext,
    input  logic          div4_sel,
    input  logic          pre_bypass,
    input  logic [RW-1:0] pre_ratio,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          ovf_clr,
    output logic [CW-1:0] count_q,
    output logic          ovf_flag
);
    logic int_tick, ext_tick, src_tick, cnt_tick;

    tmr8_phase u_phase (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .div4_sel (div4_sel),
        .int_tick (int_tick)
    );

    tmr8_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .pin       (ext_pin),
        .fall_sel  (edge_fall),
        .edge_tick (ext_tick)
    );

    assign src_tick = src_ext ? ext_tick : int_tick;

    tmr8_presc #(.RW(RW)) u_presc (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .bypass   (pre_bypass),
        .ratio    (pre_ratio),
        .clr      (wr_en),
        .out_tick (cnt_tick)
    );

    tmr8_core #(.CW(CW)) u_core (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .tick     (cnt_tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ovf_clr  (ovf_clr),
        .count_q  (count_q),
        .ovf_flag (ovf_flag)
    );
endmodule

// File: rtl/tmr8_unit_chk.sv
module tmr8_unit_chk #(
    parameter int CW = 8
) (
    input logic          clk_osc,
    input logic          rst_n,
    input logic          wr_en,
    input logic [CW-1:0] wr_data,
    input logic          ovf_clr,
    input logic [CW-1:0] count_q,
    input logic          ovf_flag
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    // R5: a write is visible on the next cycle
    a_r5_write_loads: assert property (@(posedge clk_osc) disable iff (!rst_n)
        wr_en |=> count_q == $past(wr_data));

    // R2: without a write the counter moves by at most one
    a_r2_single_step: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !wr_en |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + CW'(1)));

    // R6: leaving the top value to zero without a write sets the flag
    a_r6_rollover_sets: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (count_q == TOP && !wr_en) |=> (count_q != '0) || ovf_flag);

    // R7: the flag is held without a clear
    a_r7_flag_sticky: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R7: a clear with no roll-over possible empties the flag
    a_r7_clear_works: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (ovf_clr && count_q != TOP) |=> !ovf_flag);
endmodule

bind tmr8_unit tmr8_unit_chk #(.CW(CW)) u_chk (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ovf_clr  (ovf_clr),
    .count_q  (count_q),
    .ovf_flag (ovf_flag)
);

// File: tb/tmr8_unit_test.sv
module tmr8_unit_test;
    logic       clk_osc = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0, edge_fall = 1'b0, src_ext = 1'b0, div4_sel = 1'b0;
    logic       pre_bypass = 1'b1, wr_en = 1'b0, ovf_clr = 1'b0;
    logic [2:0] pre_ratio = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] count_q;
    logic       ovf_flag;

    int    n_cmp = 0, n_bad = 0;
    bit    cmp_on = 1'b0, done = 1'b0;
    string tag = "R1";

    // reference state, built from the requirements
    int         m_ph;
    logic       m_s1, m_s2, m_lvl, m_ovf;
    logic [7:0] m_pre, m_cnt;

    always #2 clk_osc = ~clk_osc;   // 250 MHz

    tmr8_unit uut (
        .clk_osc(clk_osc), .rst_n(rst_n), .ext_pin(ext_pin), .edge_fall(edge_fall),
        .src_ext(src_ext), .div4_sel(div4_sel), .pre_bypass(pre_bypass),
        .pre_ratio(pre_ratio), .wr_en(wr_en), .wr_data(wr_data), .ovf_clr(ovf_clr),
        .count_q(count_q), .ovf_flag(ovf_flag)
    );

    function automatic logic pre_pass(logic [7:0] p, logic [2:0] k, logic byp);
        logic [7:0] msk = 8'hFF >> (3'd7 - k);
        return byp || ((p & msk) == msk);
    endfunction

    always @(posedge clk_osc) begin
        if (!rst_n) begin
            m_ph = 0; m_s1 = 0; m_s2 = 0; m_lvl = 0;
            m_pre = 0; m_cnt = 0; m_ovf = 0;
        end else begin
            logic it, et, st, ct;
            it = div4_sel ? (m_ph == 3) : (m_ph == 1);
            et = edge_fall ? (m_lvl && !m_s2) : (!m_lvl && m_s2);
            st = src_ext ? et : it;
            ct = st && pre_pass(m_pre, pre_ratio, pre_bypass);
            m_ph  = (m_ph == 1 && !div4_sel) ? 0 : (m_ph + 1) % 4;
            m_lvl = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
            if (wr_en) m_pre = 0;
            else if (st && !pre_bypass) m_pre = m_pre + 8'd1;
            if (ct && !wr_en && m_cnt == 8'hFF) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            if (wr_en) m_cnt = wr_data;
            else if (ct) m_cnt = m_cnt + 8'd1;
        end
    end

    task automatic chk(string t, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", t, act, exp, $time);
        end
    endtask

    always @(negedge clk_osc) if (cmp_on && rst_n) begin
        chk(tag, count_q, m_cnt);
        chk({tag, " flag"}, {7'd0, ovf_flag}, {7'd0, m_ovf});
    end

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) @(negedge clk_osc);
    endtask

    task automatic load(logic [7:0] v);
        @(negedge clk_osc); wr_en = 1; wr_data = v;
        @(negedge clk_osc); wr_en = 0;
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd1234));
        // R1 reset state
        #1; chk("R1", count_q, 8'h00); chk("R1 flag", {7'd0, ovf_flag}, 8'h00);
        run(3); rst_n = 1; cmp_on = 1;

        tag = "R2 div2"; run(24);
        tag = "R2 div4"; div4_sel = 1; run(24);
        tag = "R2 write keeps phase"; load(8'h10); run(12);

        tag = "R3 ratio";
        pre_bypass = 0; div4_sel = 0;
        for (int k = 0; k < 8; k++) begin
            pre_ratio = 3'(k); load(8'h00); run((2 << k) * 6 + 8);
        end

        tag = "R4 rising"; pre_bypass = 1; src_ext = 1; edge_fall = 0;
        for (int i = 0; i < 20; i++) begin ext_pin = ~ext_pin; run(2 + $urandom_range(0, 4)); end
        tag = "R4 falling"; edge_fall = 1;
        for (int i = 0; i < 20; i++) begin ext_pin = ~ext_pin; run(2 + $urandom_range(0, 4)); end

        tag = "R5 write clears prescaler"; src_ext = 0; pre_bypass = 0; pre_ratio = 3'd2;
        run(9); load(8'h40); chk("R5 load", count_q, 8'h40); run(40);
        tag = "R5 write beats tick"; pre_bypass = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_osc); wr_en = 1; wr_data = 8'(8'h20 + i);
        end
        @(negedge clk_osc); wr_en = 0; run(6);

        tag = "R6 rollover"; load(8'hFD); run(10);
        chk("R6 set", {7'd0, ovf_flag}, 8'h01);
        tag = "R6 write zero"; ovf_clr = 1; run(1); ovf_clr = 0;
        load(8'hFF); load(8'h00); run(2);
        tag = "R7 sticky/clear"; load(8'hFE); run(12);
        ovf_clr = 1; run(1); ovf_clr = 0; run(2);
        chk("R7 cleared", {7'd0, ovf_flag}, 8'h00);
        tag = "R7 set wins"; load(8'hFF); ovf_clr = 1; run(4); ovf_clr = 0; run(4);

        tag = "R3 random mix";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk_osc);
            src_ext = $urandom_range(0, 3) == 0; div4_sel = $urandom_range(0, 1) == 1;
            pre_bypass = $urandom_range(0, 2) == 0; pre_ratio = 3'($urandom_range(0, 2));
            edge_fall = $urandom_range(0, 1) == 1;
            wr_en = $urandom_range(0, 19) == 0; wr_data = 8'($urandom_range(240, 255));
            ovf_clr = $urandom_range(0, 9) == 0;
            for (int j = 0; j < 3; j++) begin
                if (j == 1) begin wr_en = 0; ovf_clr = 0; end
                if ($urandom_range(0, 1) == 1) ext_pin = ~ext_pin;
                run(2);
            end
        end
        wr_en = 0; ovf_clr = 0;

        // R1 reset in mid-run
        cmp_on = 0; @(negedge clk_osc); rst_n = 0; #1;
        chk("R1 mid", count_q, 8'h00); chk("R1 mid flag", {7'd0, ovf_flag}, 8'h00);
        run(2);
        report();
    end
endmodule